// File: doc/BRIEF.md
# Nested Priority Interrupt Controller

This block decides which exception a processor core should service next. It watches a parameterised set of peripheral interrupt lines plus two system exceptions with fixed urgency: a fault exception and a reset exception. Each source is always in one of four states: idle, pending, active, or active with a fresh request waiting. The controller picks the most urgent eligible pending source and decides whether it may interrupt the handler that is running. It then tells the core to enter that handler with a one-cycle entry strobe.

The core is modelled by two strobes. The controller drives the entry strobe, and the core drives an exit strobe when a handler finishes. Handlers nest, and the controller remembers the order of entry, so an exit always retires the handler entered most recently. When a handler exits and a waiting source may run at the level being returned to, the controller chains straight into that source. It gives no return indication first.

Software configures the block through a small word-addressed register port. That port has a set-only enable register, set-pending and clear-pending registers, a grouping field and one 3-bit priority field per line. A lower priority value is more urgent. The grouping field splits each priority into a preemption part and a subpriority part.

Top module: `prio_irq_ctrl`

## Requirements
- R1: After synchronous reset, every enable, pending bit, active bit, priority field and the grouping field read 0. `entry_o` and `ret_o` are low, and `exec_prio_o` shows 8, which means no handler is active.
- R2: A peripheral line `irq_i[k]` that is high at a clock edge makes source k pending only if enable bit k is set. A line whose enable is clear is ignored. A software set-pending write (address 1, write-data bit k) makes source k pending whatever its enable is. A pending source is considered for entry only while it is enabled.
- R3: A write to address 0 sets every enable bit whose write-data bit is 1. A write-data bit of 0 leaves its enable bit unchanged. Reading address 0 returns the enable mask in bits NUM_IRQ-1..0.
- R4: Reading address 1 returns the pending mask, and reading address 2 returns the active mask. Both are indexed by source: peripheral k at bit k, fault at bit NUM_IRQ, reset at bit NUM_IRQ+1. A request to an active source leaves it both active and pending. A clear-pending write (address 2, write-data bit k) takes pending to idle and active-and-pending to active. Register reads return data in the cycle after the read strobe.
- R5: The effective priority is -3 for reset, -1 for fault, and the 3-bit field (written at address 4+k) for peripheral k. The lowest effective value wins among eligible pending sources, and a tie goes to the lower source index. `entry_id_o` gives the source index.
- R6: The grouping field (address 3) gives the number of low priority bits that form the subpriority, from 0 to 3. Only the remaining upper bits, the preemption value, decide whether a pending source may interrupt a running handler.
- R7: A pending source enters while a handler is running only when its preemption value is strictly below `exec_prio_o`. After such an entry, both the old and the new source are active.
- R8: The exit strobe clears the active bit of the most recently entered source that is still active. Handlers entered earlier stay active.
- R9: If, at an exit, the best eligible pending source has a preemption value below the level that remains after the exit, it is entered at that same edge. `entry_o` and `entry_chain_o` are high and `ret_o` stays low.
- R10: An exit with no such source raises `ret_o` for one cycle with `entry_o` low.
- R11: A source made pending at clock edge E is entered at edge E+1 if it is eligible. Entry clears its pending bit, sets its active bit and raises `entry_o` for one cycle.
- R12: `exec_prio_o` is a 5-bit two's-complement value. It equals the lowest preemption value among the active sources (reset -3, fault -1), or 8 when none is active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_i | input | NUM_IRQ | Peripheral interrupt request lines |
| fault_i | input | 1 | Fault exception request |
| rst_exc_i | input | 1 | Reset exception request |
| reg_wr_i | input | 1 | Register write strobe |
| reg_rd_i | input | 1 | Register read strobe |
| reg_addr_i | input | AW | Register word address |
| reg_wdata_i | input | DW | Register write data |
| reg_rdata_o | output | DW | Register read data, one cycle after the read strobe |
| exit_i | input | 1 | Handler exit strobe from the core |
| entry_o | output | 1 | One-cycle handler entry strobe |
| entry_id_o | output | IDW | Source index being entered |
| entry_chain_o | output | 1 | Entry chained from a handler exit |
| ret_o | output | 1 | One-cycle return to the lower level |
| exec_prio_o | output | PRIO_W+2 | Current execution priority, signed; 8 means none |

## Verification
Two functions can meet in one edge: a handler exit and a handler entry. They meet whenever a request is pending at the moment the core pulses exit. The bench provokes this in three ways. It re-requests the running source, it queues several sources so that successive exits walk through them, and it holds a source that cannot preempt the running handler until the handler retires. In the same cycle as the exit strobe, it judges `entry_o`, `entry_chain_o`, `entry_id_o` and `ret_o` together. It also sets up the opposite case, where the waiting source only matches the restored level, to show that a plain return is taken instead of a chain.

// File: rtl/pic_pkg.sv
package pic_pkg;
  // Register word addresses
  localparam int ADDR_SETEN     = 0;
  localparam int ADDR_SETPEND   = 1;  // write: set pending, read: pending mask
  localparam int ADDR_CLRPEND   = 2;  // write: clear pending, read: active mask
  localparam int ADDR_GROUP     = 3;
  localparam int ADDR_PRIO_BASE = 4;

  // Fixed effective priorities of the system exceptions
  localparam int FAULT_LEVEL = -1;
  localparam int RESET_LEVEL = -3;
endpackage

// File: rtl/pic_cfg.sv
module pic_cfg
  import pic_pkg::*;
#(
  parameter int NUM_IRQ = 8,
  parameter int PRIO_W  = 3,
  parameter int DW      = 32,
  parameter int AW      = 4,
  localparam int NSRC   = NUM_IRQ + 2,
  localparam int LW     = PRIO_W + 2,
  localparam int GW     = $clog2(PRIO_W + 1)
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     wr,
  input  logic                     rd,
  input  logic [AW-1:0]            addr,
  input  logic [DW-1:0]            wdata,
  input  logic [NSRC-1:0]          pend,
  input  logic [NSRC-1:0]          act,
  output logic [DW-1:0]            rdata,
  output logic [NSRC-1:0]          en_m,
  output logic [NSRC-1:0]          sw_set,
  output logic [NSRC-1:0]          sw_clr,
  output logic [NSRC-1:0][LW-1:0]  pre_v,
  output logic [NSRC-1:0][LW-1:0]  full_v
);
  logic [NUM_IRQ-1:0]             en_q;
  logic [NUM_IRQ-1:0][PRIO_W-1:0] prio_q;
  logic [GW-1:0]                  grp_q;
  logic [PRIO_W-1:0]              hi_mask;
  logic [DW-1:0]                  rdata_q;
  int                             a_i;
  logic                           unused_wdata;

  assign a_i          = int'(addr);
  assign unused_wdata = ^wdata;

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q   <= '0;
      prio_q <= '0;
      grp_q  <= '0;
    end else if (wr) begin
      if (a_i == ADDR_SETEN) en_q <= en_q | wdata[NUM_IRQ-1:0];
      if (a_i == ADDR_GROUP) begin
        if (int'(wdata[GW-1:0]) > PRIO_W) grp_q <= GW'(PRIO_W);
        else                              grp_q <= wdata[GW-1:0];
      end
      for (int k = 0; k < NUM_IRQ; k++) begin
        if (a_i == ADDR_PRIO_BASE + k) prio_q[k] <= wdata[PRIO_W-1:0];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata_q <= '0;
    end else if (rd) begin
      rdata_q <= '0;
      if (a_i == ADDR_SETEN)   rdata_q <= DW'(en_q);
      if (a_i == ADDR_SETPEND) rdata_q <= DW'(pend);
      if (a_i == ADDR_CLRPEND) rdata_q <= DW'(act);
      if (a_i == ADDR_GROUP)   rdata_q <= DW'(grp_q);
      for (int k = 0; k < NUM_IRQ; k++) begin
        if (a_i == ADDR_PRIO_BASE + k) rdata_q <= DW'(prio_q[k]);
      end
    end
  end
  assign rdata = rdata_q;

  assign sw_set = (wr && a_i == ADDR_SETPEND) ? {2'b00, wdata[NUM_IRQ-1:0]} : '0;
  assign sw_clr = (wr && a_i == ADDR_CLRPEND) ? {2'b00, wdata[NUM_IRQ-1:0]} : '0;
  assign en_m   = {2'b11, en_q};

  // Upper bits of a priority form the preemption value
  assign hi_mask = {PRIO_W{1'b1}} << grp_q;

  for (genvar g = 0; g < NUM_IRQ; g++) begin : g_irq_lvl
    assign full_v[g] = {2'b00, prio_q[g]};
    assign pre_v[g]  = {2'b00, prio_q[g] & hi_mask};
  end
  assign full_v[NUM_IRQ]   = LW'(FAULT_LEVEL);
  assign pre_v[NUM_IRQ]    = LW'(FAULT_LEVEL);
  assign full_v[NUM_IRQ+1] = LW'(RESET_LEVEL);
  assign pre_v[NUM_IRQ+1]  = LW'(RESET_LEVEL);

  // R3: enable bits only ever rise
  assert_enable_sticky_R3: assert property (@(posedge clk) disable iff (rst)
    (en_q & $past(en_q)) == $past(en_q));
  // R6: grouping field stays within the priority width
  assert_group_range_R6: assert property (@(posedge clk) disable iff (rst)
    int'(grp_q) <= PRIO_W);
endmodule

// File: rtl/pic_pick.sv
module pic_pick #(
  parameter int NUM_IRQ = 8,
  parameter int PRIO_W  = 3,
  localparam int NSRC   = NUM_IRQ + 2,
  localparam int IDW    = $clog2(NSRC),
  localparam int LW     = PRIO_W + 2
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic [NSRC-1:0]         cand,
  input  logic [NSRC-1:0][LW-1:0] full_v,
  input  logic [NSRC-1:0][LW-1:0] pre_v,
  output logic                    any,
  output logic [IDW-1:0]          win_id,
  output logic [LW-1:0]           win_pre
);
  logic [LW-1:0] best;

  // Strict comparison keeps the lower index on a tie
  always_comb begin
    any    = 1'b0;
    win_id = '0;
    best   = '0;
    for (int i = 0; i < NSRC; i++) begin
      if (cand[i] && (!any || $signed(full_v[i]) < $signed(best))) begin
        any    = 1'b1;
        win_id = IDW'(i);
        best   = full_v[i];
      end
    end
  end
  assign win_pre = pre_v[win_id];

  // R5: the chosen source is an eligible pending one
  assert_winner_pending_R5: assert property (@(posedge clk) disable iff (rst)
    any |-> cand[win_id]);
  // R5: nothing eligible means no winner
  assert_no_cand_no_win_R5: assert property (@(posedge clk) disable iff (rst)
    (cand == '0) |-> !any);
endmodule

// File: rtl/pic_lvl.sv
module pic_lvl #(
  parameter int NUM_IRQ = 8,
  parameter int PRIO_W  = 3,
  localparam int NSRC   = NUM_IRQ + 2,
  localparam int LW     = PRIO_W + 2
) (
  input  logic [NSRC-1:0]         mask,
  input  logic [NSRC-1:0][LW-1:0] pre_v,
  output logic [LW-1:0]           lvl
);
  localparam logic [LW-1:0] NONE_V = LW'(1 << PRIO_W);

  always_comb begin
    lvl = NONE_V;
    for (int i = 0; i < NSRC; i++) begin
      if (mask[i] && $signed(pre_v[i]) < $signed(lvl)) lvl = pre_v[i];
    end
  end
endmodule

// File: rtl/pic_track.sv
module pic_track #(
  parameter int NUM_IRQ = 8,
  parameter int PRIO_W  = 3,
  localparam int NSRC   = NUM_IRQ + 2,
  localparam int IDW    = $clog2(NSRC),
  localparam int LW     = PRIO_W + 2,
  localparam int SDEP   = (1 << PRIO_W) + 2,
  localparam int PW     = $clog2(SDEP + 1)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [NSRC-1:0] set_m,
  input  logic [NSRC-1:0] clr_m,
  input  logic            exit_i,
  input  logic            win_any,
  input  logic [IDW-1:0]  win_id,
  input  logic [LW-1:0]   win_pre,
  input  logic [LW-1:0]   lvl_after,
  input  logic [LW-1:0]   lvl_next,
  output logic [NSRC-1:0] pend_q,
  output logic [NSRC-1:0] act_q,
  output logic [NSRC-1:0] act_after,
  output logic [NSRC-1:0] act_next,
  output logic            entry_o,
  output logic [IDW-1:0]  entry_id_o,
  output logic            chain_o,
  output logic            ret_o,
  output logic [LW-1:0]   exec_o
);
  localparam logic [LW-1:0] NONE_V = LW'(1 << PRIO_W);

  logic [IDW-1:0]  stk [SDEP];
  logic [PW-1:0]   ptr;
  logic [IDW-1:0]  top_id;
  logic            pop, room, take;
  logic [NSRC-1:0] take_oh, pend_n;

  assign pop     = exit_i && (ptr != '0);
  assign top_id  = (ptr != '0) ? stk[ptr - PW'(1)] : '0;
  assign act_after = act_q & ~(pop ? (NSRC'(1) << top_id) : '0);
  assign room    = pop || (int'(ptr) < SDEP);
  assign take    = win_any && room && ($signed(win_pre) < $signed(lvl_after));
  assign take_oh = take ? (NSRC'(1) << win_id) : '0;
  assign act_next = act_after | take_oh;
  assign pend_n  = (pend_q & ~clr_m & ~take_oh) | set_m;

  // Entry order memory
  always_ff @(posedge clk) begin
    if (take) begin
      if (pop) stk[ptr - PW'(1)] <= win_id;
      else     stk[ptr]          <= win_id;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_q     <= '0;
      act_q      <= '0;
      ptr        <= '0;
      entry_o    <= 1'b0;
      entry_id_o <= '0;
      chain_o    <= 1'b0;
      ret_o      <= 1'b0;
      exec_o     <= NONE_V;
    end else begin
      pend_q  <= pend_n;
      act_q   <= act_next;
      if (take && !pop)      ptr <= ptr + PW'(1);
      else if (pop && !take) ptr <= ptr - PW'(1);
      entry_o <= take;
      if (take) entry_id_o <= win_id;
      chain_o <= take && pop;
      ret_o   <= pop && !take;
      exec_o  <= lvl_next;
    end
  end

  // R8: nesting depth stays within the entry memory
  assert_stack_bound_R8: assert property (@(posedge clk) disable iff (rst)
    int'(ptr) <= SDEP);
  // R7: an entry always lowers the execution level below the prior level
  assert_entry_lowers_level_R7: assert property (@(posedge clk) disable iff (rst)
    entry_o |-> $signed(exec_o) < $signed($past(lvl_after)));
  // R10: every exit of a live handler is answered by a chain or a return
  assert_exit_answered_R10: assert property (@(posedge clk) disable iff (rst)
    (exit_i && ptr != '0) |=> (entry_o || ret_o));
  // R9: a chained entry only follows an exit strobe
  assert_chain_after_exit_R9: assert property (@(posedge clk) disable iff (rst)
    chain_o |-> $past(exit_i));
  // R12: execution level shows none exactly when nothing is active
  assert_exec_tracks_active_R12: assert property (@(posedge clk) disable iff (rst)
    (act_q == '0) == (exec_o == NONE_V));
  // R11: an entered source is active
  assert_entry_sets_active_R11: assert property (@(posedge clk) disable iff (rst)
    entry_o |-> act_q[entry_id_o]);
endmodule

// File: rtl/prio_irq_ctrl.sv
module prio_irq_ctrl #(
  parameter int NUM_IRQ = 8,
  parameter int PRIO_W  = 3,
  parameter int DW      = 32,
  parameter int AW      = 4,
  localparam int NSRC   = NUM_IRQ + 2,
  localparam int IDW    = $clog2(NSRC),
  localparam int LW     = PRIO_W + 2
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_IRQ-1:0] irq_i,
  input  logic               fault_i,
  input  logic               rst_exc_i,
  input  logic               reg_wr_i,
  input  logic               reg_rd_i,
  input  logic [AW-1:0]      reg_addr_i,
  input  logic [DW-1:0]      reg_wdata_i,
  output logic [DW-1:0]      reg_rdata_o,
  input  logic               exit_i,
  output logic               entry_o,
  output logic [IDW-1:0]     entry_id_o,
  output logic               entry_chain_o,
  output logic               ret_o,
  output logic [LW-1:0]      exec_prio_o
);
  logic [NSRC-1:0]         en_m, sw_set, sw_clr, set_m, cand;
  logic [NSRC-1:0]         pend_q, act_q, act_after, act_next;
  logic [NSRC-1:0][LW-1:0] pre_v, full_v;
  logic                    win_any;
  logic [IDW-1:0]          win_id;
  logic [LW-1:0]           win_pre, lvl_after, lvl_next;

  pic_cfg #(.NUM_IRQ(NUM_IRQ), .PRIO_W(PRIO_W), .DW(DW), .AW(AW)) u_cfg (
    .clk(clk), .rst(rst), .wr(reg_wr_i), .rd(reg_rd_i), .addr(reg_addr_i),
    .wdata(reg_wdata_i), .pend(pend_q), .act(act_q), .rdata(reg_rdata_o),
    .en_m(en_m), .sw_set(sw_set), .sw_clr(sw_clr), .pre_v(pre_v), .full_v(full_v)
  );

  // Hardware requests count only on enabled lines; system exceptions always count
  assign set_m = {rst_exc_i, fault_i, irq_i & en_m[NUM_IRQ-1:0]} | sw_set;
  assign cand  = pend_q & en_m;

  pic_pick #(.NUM_IRQ(NUM_IRQ), .PRIO_W(PRIO_W)) u_pick (
    .clk(clk), .rst(rst), .cand(cand), .full_v(full_v), .pre_v(pre_v),
    .any(win_any), .win_id(win_id), .win_pre(win_pre)
  );

  pic_lvl #(.NUM_IRQ(NUM_IRQ), .PRIO_W(PRIO_W)) u_lvl_dec (
    .mask(act_after), .pre_v(pre_v), .lvl(lvl_after)
  );

  pic_lvl #(.NUM_IRQ(NUM_IRQ), .PRIO_W(PRIO_W)) u_lvl_exec (
    .mask(act_next), .pre_v(pre_v), .lvl(lvl_next)
  );

  pic_track #(.NUM_IRQ(NUM_IRQ), .PRIO_W(PRIO_W)) u_track (
    .clk(clk), .rst(rst), .set_m(set_m), .clr_m(sw_clr), .exit_i(exit_i),
    .win_any(win_any), .win_id(win_id), .win_pre(win_pre),
    .lvl_after(lvl_after), .lvl_next(lvl_next),
    .pend_q(pend_q), .act_q(act_q), .act_after(act_after), .act_next(act_next),
    .entry_o(entry_o), .entry_id_o(entry_id_o), .chain_o(entry_chain_o),
    .ret_o(ret_o), .exec_o(exec_prio_o)
  );
endmodule

// File: tb/test_prio_irq_ctrl.sv
module test_prio_irq_ctrl;
  localparam int A_EN = 0, A_SP = 1, A_CP = 2, A_GRP = 3, A_PR = 4;
  localparam logic [31:0] NONE = 32'd8, L_RST = 32'h1D, L_FLT = 32'h1F;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [7:0]  irq = '0;
  logic        fault = 1'b0, rexc = 1'b0;
  logic        reg_wr = 1'b0, reg_rd = 1'b0;
  logic [3:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0, reg_rdata;
  logic        exit_s = 1'b0;
  logic        entry, chain, ret;
  logic [3:0]  entry_id;
  logic [4:0]  exec_prio;
  int          errors = 0, checks = 0;
  bit          done = 1'b0;
  logic [31:0] q;

  always #5 clk = ~clk;

  prio_irq_ctrl i_prio_irq_ctrl (
    .clk(clk), .rst(rst), .irq_i(irq), .fault_i(fault), .rst_exc_i(rexc),
    .reg_wr_i(reg_wr), .reg_rd_i(reg_rd), .reg_addr_i(reg_addr),
    .reg_wdata_i(reg_wdata), .reg_rdata_o(reg_rdata), .exit_i(exit_s),
    .entry_o(entry), .entry_id_o(entry_id), .entry_chain_o(chain),
    .ret_o(ret), .exec_prio_o(exec_prio)
  );

  task automatic chk(input string tag, input logic [31:0] actv, input logic [31:0] expv);
    checks++;
    if (actv !== expv) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, actv, expv);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  task automatic wr(input int a, input logic [31:0] d);
    reg_wr = 1'b1; reg_addr = 4'(a); reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input int a, output logic [31:0] v);
    reg_rd = 1'b1; reg_addr = 4'(a);
    @(negedge clk);
    reg_rd = 1'b0;
    v = reg_rdata;
  endtask

  task automatic pulse(input int k);
    irq[k] = 1'b1;
    @(negedge clk);
    irq[k] = 1'b0;
  endtask

  task automatic do_exit();
    exit_s = 1'b1;
    @(negedge clk);
    exit_s = 1'b0;
  endtask

  task automatic chk_entry(input string tag, input int id, input bit ch, input logic [31:0] lvl);
    chk({tag, " entry"}, 32'(entry), 32'd1);
    chk({tag, " id"}, 32'(entry_id), 32'(id));
    chk({tag, " chain"}, 32'(chain), 32'(ch));
    chk({tag, " ret"}, 32'(ret), 32'd0);
    chk({tag, " exec"}, 32'(exec_prio), lvl);
  endtask

  task automatic chk_ret(input string tag, input logic [31:0] lvl);
    chk({tag, " ret"}, 32'(ret), 32'd1);
    chk({tag, " entry"}, 32'(entry), 32'd0);
    chk({tag, " exec"}, 32'(exec_prio), lvl);
  endtask

  task automatic t_reset();  // R1
    chk("R1 entry", 32'(entry), 0);
    chk("R1 ret", 32'(ret), 0);
    chk("R1 exec", 32'(exec_prio), NONE);
    rd(A_EN, q);    chk("R1 enable", q, 0);
    rd(A_SP, q);    chk("R1 pending", q, 0);
    rd(A_CP, q);    chk("R1 active", q, 0);
    rd(A_GRP, q);   chk("R1 group", q, 0);
    rd(A_PR + 5, q); chk("R1 prio5", q, 0);
  endtask

  task automatic t_enable();  // R3
    wr(A_EN, 32'h05); rd(A_EN, q); chk("R3 set", q, 32'h05);
    wr(A_EN, 32'h02); rd(A_EN, q); chk("R3 zero bits keep", q, 32'h07);
    wr(A_EN, 32'h00); rd(A_EN, q); chk("R3 zero write", q, 32'h07);
    wr(A_EN, 32'h7F); rd(A_EN, q); chk("R3 more", q, 32'h7F);
  endtask

  task automatic t_disabled();  // R2, R11, R10
    pulse(7); step;
    chk("R2 disabled line no entry", 32'(entry), 0);
    rd(A_SP, q); chk("R2 disabled line not pending", q, 0);
    wr(A_SP, 32'h80); step;
    chk("R2 sw pend disabled no entry", 32'(entry), 0);
    rd(A_SP, q); chk("R2 sw pend sets", q, 32'h80);
    wr(A_EN, 32'h80); step;
    chk_entry("R11 enable releases", 7, 0, 0);
    do_exit; chk_ret("R10 plain return", NONE);
    pulse(1); step;
    chk_entry("R11 hw line", 1, 0, 0);
    rd(A_SP, q); chk("R11 pending cleared", q, 0);
    do_exit; chk_ret("R10 return", NONE);
  endtask

  task automatic t_states();  // R4, R9, R10
    wr(A_PR + 2, 4); wr(A_PR + 3, 2);
    rd(A_PR + 2, q); chk("R5 prio readback", q, 4);
    pulse(2); step;
    chk_entry("R11 irq2", 2, 0, 4);
    rd(A_CP, q); chk("R4 active", q, 32'h004);
    pulse(2); step;
    chk("R7 same source no reentry", 32'(entry), 0);
    rd(A_SP, q); chk("R4 act+pend pending", q, 32'h004);
    rd(A_CP, q); chk("R4 act+pend active", q, 32'h004);
    wr(A_CP, 32'h04);
    rd(A_SP, q); chk("R4 clear to active pend", q, 0);
    rd(A_CP, q); chk("R4 clear to active act", q, 32'h004);
    pulse(2);
    do_exit; chk_entry("R9 chain self", 2, 1, 4);
    do_exit; chk_ret("R10 after chain", NONE);
    rd(A_CP, q); chk("R8 all retired", q, 0);
  endtask

  task automatic t_order();  // R5, R7, R9
    wr(A_PR + 4, 2); wr(A_PR + 5, 6);
    wr(A_SP, 32'h38); step;
    chk_entry("R5 tie lower index", 3, 0, 2);
    step;
    chk("R7 equal level no preempt", 32'(entry), 0);
    do_exit; chk_entry("R9 chain irq4", 4, 1, 2);
    do_exit; chk_entry("R9 chain irq5", 5, 1, 6);
    do_exit; chk_ret("R10 order end", NONE);
  endtask

  task automatic t_fixed();  // R5, R12
    rexc = 1'b1; fault = 1'b1;
    reg_wr = 1'b1; reg_addr = 4'(A_SP); reg_wdata = 32'h01;
    step;
    rexc = 1'b0; fault = 1'b0; reg_wr = 1'b0;
    step;
    chk_entry("R5 reset first", 9, 0, L_RST);
    do_exit; chk_entry("R5 fault second", 8, 1, L_FLT);
    do_exit; chk_entry("R5 prog zero third", 0, 1, 0);
    do_exit; chk_ret("R12 none after fixed", NONE);
  endtask

  task automatic t_nest();  // R7, R8, R12
    pulse(5); step; chk_entry("R7 base irq5", 5, 0, 6);
    pulse(2); step; chk_entry("R7 preempt irq2", 2, 0, 4);
    rd(A_CP, q); chk("R7 both active", q, 32'h024);
    pulse(0); step; chk_entry("R7 preempt irq0", 0, 0, 0);
    do_exit; chk_ret("R8 pop irq0", 4);
    rd(A_CP, q); chk("R8 earlier stay", q, 32'h024);
    do_exit; chk_ret("R8 pop irq2", 6);
    rd(A_CP, q); chk("R8 only irq5", q, 32'h020);
    do_exit; chk_ret("R12 none", NONE);
  endtask

  task automatic t_group();  // R6
    wr(A_GRP, 1); rd(A_GRP, q); chk("R6 group readback", q, 1);
    wr(A_PR + 6, 5);
    pulse(6); step; chk_entry("R6 preempt part of 5", 6, 0, 4);
    pulse(2); step;
    chk("R6 subpriority no preempt", 32'(entry), 0);
    rd(A_SP, q); chk("R6 waiting pending", q, 32'h004);
    pulse(3); step; chk_entry("R6 upper bits preempt", 3, 0, 2);
    do_exit; chk_ret("R6 no chain at equal level", 4);
    do_exit; chk_entry("R9 chain after base exits", 2, 1, 4);
    do_exit; chk_ret("R10 group end", NONE);
    wr(A_GRP, 0);
  endtask

  initial begin
    repeat (3) step;
    rst = 1'b0;
    step;
    t_reset();
    t_enable();
    t_disabled();
    t_states();
    t_order();
    t_fixed();
    t_nest();
    t_group();
    step;
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule